// File: doc/BRIEF.md
# Disk Interface Interrupt Controller

This block gathers the two interrupt sources of a disk interface, a device-side completion interrupt and a bus error raised while DMA is moving data, into one level-sensitive interrupt line. Each source has a sticky pending bit. Each source also has an enable bit that software sets through a write-one register. A separate write-one register clears pending bits. When the first bus error arrives, the block captures the 64-bit address that failed. Software reads that address as two 32-bit words. The address stays frozen until software clears the error bit.

The block also watches reads of the attached device's status register. A read clears the pending device interrupt, but only if the value read shows the device has finished, meaning any of bits 0, 4 or 6 is set, and only if the busy bit 7 is clear. A busy device therefore never has its interrupt treated as serviced.

Register access uses one request strobe. No back-pressure is applied: every request is accepted in the cycle it is presented. Read data returns exactly one cycle later, marked by a valid pulse, with no ready signal. The event inputs are single-cycle pulses and are never stalled.

Top module: `ide_irq_ctrl`

## Requirements
- R1: After reset, both pending bits and both enable bits are 0, the captured address is 0 and `irq_o` is low.
- R2: A `dev_evt` pulse sets pending bit 0 and an `err_evt` pulse sets pending bit 1. Reading word index 3 returns the pending bits in bits [1:0], whatever the enables are.
- R3: Writing word index 5 sets each enable bit whose data bit (bit 0 for the device source, bit 1 for the error source) is 1. Zero bits leave the enables unchanged. Reading index 5 returns the enable mask in bits [1:0].
- R4: `irq_o` is high exactly when some source is both pending and enabled. It follows the state one clock edge after the causing event or write.
- R5: Writing word index 7 clears each pending bit whose data bit is 1. Zero bits have no effect, so 0x03 clears both.
- R6: When a new event and a clear (register write or status-read clear) reach the same pending bit in the same cycle, the bit ends up set.
- R7: An `err_evt` that arrives while pending bit 1 is clear captures `err_addr`. Index 0 reads the low 32 bits and index 1 the high 32 bits. Errors that arrive while bit 1 is set leave the captured value unchanged, and after bit 1 is cleared the next error captures again.
- R8: A `dstat_rd` pulse whose `dstat_val` has any of bits 0, 4, 6 set and bit 7 clear clears pending bit 0. Pending bit 1 is untouched.
- R9: A `dstat_rd` with bit 7 set, or with none of bits 0, 4, 6 set, leaves pending bit 0 unchanged.
- R10: `reg_rvalid` pulses one cycle after a read request. Indices 2, 4 and 6 read 0. Writes to indices 0, 1, 2, 3, 4 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe, always accepted |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| reg_rdata | output | 32 | Read data |
| dev_evt | input | 1 | Device interrupt event pulse |
| err_evt | input | 1 | DMA bus error event pulse |
| err_addr | input | 64 | Failing address presented with `err_evt` |
| dstat_rd | input | 1 | Pulse: the device status register is being read |
| dstat_val | input | 8 | Value returned by that status read |
| irq_o | output | 1 | Level interrupt output |

## Verification
A wrong pending bit shows up on the status word at the very next read, and on `irq_o` one edge after the event once that source is enabled. The bench therefore reads the status after every stimulus rather than only at the end. A capture register that was overwritten by a second error shows up as a changed low or high word on a read while bit 1 is still set. The same-cycle event-and-clear cases and the busy-gated status-read clears each get their own stimulus, so a reversed priority or a wrongly decoded status mask changes the very next status read.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_SRC      = 2;
  localparam int SRC_DEV      = 0;
  localparam int SRC_BERR     = 1;
  localparam int IDX_ERR_LO   = 0;
  localparam int IDX_ERR_HI   = 1;
  localparam int IDX_STATUS   = 3;
  localparam int IDX_ENSET    = 5;
  localparam int IDX_CLR      = 7;
  localparam logic [7:0] DSTAT_IDLE_MASK = 8'h51;
  localparam int DSTAT_BUSY_BIT = 7;

  // True when an observed device status value means the device has finished.
  function automatic logic dstat_done(input logic [7:0] v);
    return ((v & DSTAT_IDLE_MASK) != 8'h00) && !v[DSTAT_BUSY_BIT];
  endfunction
endpackage

// File: rtl/irq_pend_bit.sv
module irq_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  // R6: a new event beats a simultaneous clear
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
  // R5: a clear with no event leaves the bit low
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o);
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en_o <= '0;
    else if (wr_i) en_o <= en_o | wdata_i;
  end

  // R3: enables move only on a set-register write and never drop
  a_r3_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o));
  a_r3_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((en_o & $past(en_o)) == $past(en_o)));
endmodule

// File: rtl/err_addr_capture.sv
module err_addr_capture #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic          held_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                addr_o <= '0;
    else if (evt_i && !held_i) addr_o <= addr_i;
  end

  // R7: once an error is pending the captured address is frozen
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    held_i |=> $stable(addr_o));
  a_r7_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !held_i) |=> (addr_o == $past(addr_i)));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import ide_irq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 3,
  parameter int N     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [N-1:0]    pend_i,
  input  logic [N-1:0]    en_i,
  input  logic [2*DW-1:0] eaddr_i,
  output logic            rvalid_o,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    case (int'(idx_i))
      IDX_ERR_LO: sel = eaddr_i[DW-1:0];
      IDX_ERR_HI: sel = eaddr_i[2*DW-1:DW];
      IDX_STATUS: sel[N-1:0] = pend_i;
      IDX_ENSET:  sel[N-1:0] = en_i;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      rdata_o  <= rd_i ? sel : '0;
    end
  end

  // R10: each read returns data exactly one cycle later
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !rvalid_o);
endmodule

// File: rtl/ide_irq_ctrl.sv
module ide_irq_ctrl
  import ide_irq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IDX_W   = 3,
  parameter int DSTAT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_req,
  input  logic               reg_we,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [DW-1:0]      reg_wdata,
  output logic               reg_rvalid,
  output logic [DW-1:0]      reg_rdata,
  input  logic               dev_evt,
  input  logic               err_evt,
  input  logic [2*DW-1:0]    err_addr,
  input  logic               dstat_rd,
  input  logic [DSTAT_W-1:0] dstat_val,
  output logic               irq_o
);
  localparam int AW = 2 * DW;
  localparam int N  = NUM_SRC;

  logic [N-1:0] set_vec, clr_vec, pend, en;
  logic         wr_en, wr_clr, rd, stat_clr;

  assign wr_en    = reg_req && reg_we && (int'(reg_idx) == IDX_ENSET);
  assign wr_clr   = reg_req && reg_we && (int'(reg_idx) == IDX_CLR);
  assign rd       = reg_req && !reg_we;
  assign stat_clr = dstat_rd && dstat_done(dstat_val[7:0]);

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_DEV]  = dev_evt;
    set_vec[SRC_BERR] = err_evt;
    clr_vec = wr_clr ? reg_wdata[N-1:0] : '0;
    if (stat_clr) clr_vec[SRC_DEV] = 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    irq_pend_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .pend_o (pend[g])
    );
  end

  irq_enable_reg #(.N(N)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_en),
    .wdata_i (reg_wdata[N-1:0]),
    .en_o    (en)
  );

  logic [AW-1:0] eaddr;
  err_addr_capture #(.AW(AW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (err_evt),
    .held_i (pend[SRC_BERR]),
    .addr_i (err_addr),
    .addr_o (eaddr)
  );

  irq_read_mux #(.DW(DW), .IDX_W(IDX_W), .N(N)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (rd),
    .idx_i    (reg_idx),
    .pend_i   (pend),
    .en_i     (en),
    .eaddr_i  (eaddr),
    .rvalid_o (reg_rvalid),
    .rdata_o  (reg_rdata)
  );

  assign irq_o = |(pend & en);

  // R4: no enabled source means no interrupt
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_o);
  // R8: a finished-device status read clears the device bit
  a_r8_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !dev_evt) |=> !pend[SRC_DEV]);
  // R9: a busy status read never clears the device bit
  a_r9_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (dstat_rd && dstat_val[7] && pend[SRC_DEV] && !wr_clr) |=> pend[SRC_DEV]);
endmodule

// File: tb/tb_ide_irq_ctrl.sv
module tb_ide_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        reg_req = 0, reg_we = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_wdata = 0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        dev_evt = 0, err_evt = 0, dstat_rd = 0;
  logic [63:0] err_addr = 0;
  logic [7:0]  dstat_val = 0;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ide_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
    .reg_rdata(reg_rdata), .dev_evt(dev_evt), .err_evt(err_evt),
    .err_addr(err_addr), .dstat_rd(dstat_rd), .dstat_val(dstat_val),
    .irq_o(irq_o)
  );

  // Monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected read response got=%h expected=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s read got=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  // Drivers: each task starts and ends at a falling edge
  task automatic wr(input int idx, input logic [31:0] d);
    reg_req = 1; reg_we = 1; reg_idx = 3'(idx); reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input int idx, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_req = 1; reg_we = 0; reg_idx = 3'(idx);
    @(negedge clk);
    reg_req = 0;
    @(negedge clk);
  endtask

  task automatic ev(input bit d, input bit er, input logic [63:0] a);
    dev_evt = d; err_evt = er; err_addr = a;
    @(negedge clk);
    dev_evt = 0; err_evt = 0;
  endtask

  task automatic sread(input logic [7:0] v);
    dstat_rd = 1; dstat_val = v;
    @(negedge clk);
    dstat_rd = 0;
  endtask

  task automatic chk_irq(input bit e, input string t);
    checks++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s irq_o got=%b expected=%b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_irq(0, "R1");
    rd(3, 0, "R1 status");
    rd(5, 0, "R1 enable");
    rd(0, 0, "R1 addr lo");
    rd(1, 0, "R1 addr hi");

    ev(1, 0, 0);
    rd(3, 32'h1, "R2 device pending");
    chk_irq(0, "R4 masked");
    wr(5, 32'h1);
    chk_irq(1, "R4 enabled");
    rd(5, 32'h1, "R3 enable set");
    wr(5, 32'h0);
    rd(5, 32'h1, "R3 zero no effect");
    wr(7, 32'h1);
    chk_irq(0, "R5 cleared");
    rd(3, 0, "R5 status");

    ev(0, 1, 64'h1234_5678_9ABC_DEF0);
    rd(3, 32'h2, "R2 error pending");
    rd(0, 32'h9ABC_DEF0, "R7 addr lo");
    rd(1, 32'h1234_5678, "R7 addr hi");
    chk_irq(0, "R4 error masked");
    wr(5, 32'h2);
    chk_irq(1, "R4 error enabled");
    rd(5, 32'h3, "R3 both enables");
    ev(0, 1, 64'hAAAA_BBBB_CCCC_DDDD);
    rd(0, 32'h9ABC_DEF0, "R7 held lo");
    rd(1, 32'h1234_5678, "R7 held hi");

    // device event and clear in the same cycle
    dev_evt = 1;
    wr(7, 32'h3);
    dev_evt = 0;
    rd(3, 32'h1, "R6 event beats clear");
    ev(0, 1, 64'h0000_0011_2233_4455);
    rd(0, 32'h2233_4455, "R7 recapture lo");
    rd(1, 32'h0000_0011, "R7 recapture hi");
    wr(7, 32'h3);
    rd(3, 0, "R5 clear both");
    chk_irq(0, "R5 irq low");

    ev(1, 0, 0);
    sread(8'hC0);
    rd(3, 32'h1, "R9 busy keeps");
    sread(8'h08);
    rd(3, 32'h1, "R9 no idle bit keeps");
    sread(8'h50);
    rd(3, 0, "R8 idle clears");
    ev(1, 1, 64'h5);
    sread(8'h01);
    rd(3, 32'h2, "R8 error untouched");
    // device event during a clearing status read
    dev_evt = 1;
    sread(8'h41);
    dev_evt = 0;
    rd(3, 32'h3, "R6 event beats status clear");
    chk_irq(1, "R4 both");

    rd(2, 0, "R10 idx2");
    rd(4, 0, "R10 idx4");
    rd(6, 0, "R10 idx6");
    wr(3, 32'h0);
    wr(0, 32'hFFFF_FFFF);
    wr(6, 32'h3);
    rd(3, 32'h3, "R10 status read-only");
    rd(0, 32'h0000_0005, "R10 addr read-only");
    wr(7, 32'h3);
    chk_irq(0, "R5 final clear");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing responses got=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule